// File: doc/BRIEF.md
# Hardware Remote Message Queue Engine

This block sits in a network interface and owns a set of circular message queues kept in a local slot store. Remote producers send enqueue packets and remote consumers send dequeue request packets; the engine turns each one into an atomic pointer update. An enqueue fetches and advances the tail of its queue, so two arrivals for one queue in the same cycle land in different slots. A dequeue fetches and advances the head, so no two readers ever get the same message. Each message fits in one packet, which makes every enqueue one indivisible step. Each request gets a response one cycle later. An enqueue response is an accept or a reject (NACK) and echoes the producer's id. A dequeue response carries the message or an empty indication, together with the reply address the consumer supplied.

Each queue has its own event mode. A wake mode reports a thread id and the queue number when the queue goes from empty to non-empty. A notify mode posts a notification message into another queue on that same transition. A counting mode posts a notification message each time a programmed number of arrivals has accumulated, which suits barrier use. Notification messages enter their target queue through a second internal enqueue path. That path shares the tail fetch-and-increment with external enqueues.

Top module: `rmq_engine`

## Requirements
- R1: An enqueue to a queue holding fewer than DEPTH (16) messages is accepted: one cycle after the request, enq_rsp_valid_o=1, enq_rsp_ok_o=1 and enq_rsp_src_o equals the request's enq_src_i.
- R2: When an external enqueue and a notification message target the same queue in the same cycle, both take distinct consecutive slots, the external message first, and a later pair of dequeues returns them in that order.
- R3: An enqueue to a queue holding DEPTH messages is answered with enq_rsp_ok_o=0 (NACK), and the queue's stored contents and order are unchanged.
- R4: A dequeue from a non-empty queue returns, one cycle later, deq_rsp_ok_o=1 with the oldest message on deq_rsp_data_o and deq_rsp_dst_o equal to the request's deq_dst_i; the head advances by exactly one.
- R5: A dequeue from an empty queue returns deq_rsp_valid_o=1, deq_rsp_ok_o=0 and deq_rsp_data_o=0.
- R6: An enqueue and a dequeue for the same queue in the same cycle are served enqueue first, so a dequeue of an empty queue in that cycle returns the message being enqueued.
- R7: With mode 2'b01 (wake), the cycle after a queue goes from empty to non-empty shows wake_valid_o=1 for one cycle, with wake_qid_o giving the queue and wake_tid_o its configured thread id; an enqueue to a non-empty queue raises no wake.
- R8: With mode 2'b10 (notify), an empty-to-non-empty transition posts into queue cfg_ntq_i of that queue a message with bit MSG_W-1 set, the queue number in its low bits and all other bits zero; it is written at the earliest on the next cycle.
- R9: With mode 2'b11 (count), every time the arrival count of the queue reaches cfg_thr_i a notify message as in R8 is posted and the count restarts; no wake is raised; a threshold of zero posts nothing.
- R10: With mode 2'b00 (off), enqueues raise no wake and post no notification.
- R11: After reset all queues are empty and no response or wake output is valid.
- R12: Queues are independent: operations on one queue never change the contents or order of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2*NQ | Per-queue event mode, 2 bits per queue |
| cfg_tid_i | input | TID_W*NQ | Per-queue thread id reported on wake |
| cfg_ntq_i | input | QW*NQ | Per-queue target queue for notification messages |
| cfg_thr_i | input | CNT_W*NQ | Per-queue arrival threshold for count mode |
| enq_valid_i | input | 1 | Enqueue packet present |
| enq_qid_i | input | QW | Enqueue target queue |
| enq_src_i | input | SRC_W | Producer id, echoed in the response |
| enq_data_i | input | MSG_W | Message to store |
| deq_valid_i | input | 1 | Dequeue request present |
| deq_qid_i | input | QW | Queue to dequeue from |
| deq_dst_i | input | DST_W | Reply address of the consumer |
| enq_rsp_valid_o | output | 1 | Enqueue response present |
| enq_rsp_ok_o | output | 1 | 1 accepted, 0 NACK (queue full) |
| enq_rsp_src_o | output | SRC_W | Echoed producer id |
| deq_rsp_valid_o | output | 1 | Dequeue response present |
| deq_rsp_ok_o | output | 1 | 1 message returned, 0 queue empty |
| deq_rsp_data_o | output | MSG_W | Dequeued message, zero when empty |
| deq_rsp_dst_o | output | DST_W | Reply address for the returned message |
| wake_valid_o | output | 1 | Wake event present |
| wake_qid_o | output | QW | Queue that went non-empty |
| wake_tid_o | output | TID_W | Thread id to wake |

## Verification
On every cycle the assertions check that each request gets its response exactly one cycle later, that no queue's occupancy exceeds its depth, and that two writes in one cycle never share a slot. They also check that the head stays put without a dequeue, that an empty reply carries zero data, and that a wake only names a queue in wake mode. First-in-first-out order across a full queue, the reject of the seventeenth message with its contents intact, the enqueue-before-dequeue rule and the exact notification message contents and counts can only be shown by the bench's fill, drain and event scenarios, whose expected data are computed from queue and index numbers.

// File: rtl/rmq_pkg.sv
package rmq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_WAKE  = 2'b01,
    MODE_NOTE  = 2'b10,
    MODE_COUNT = 2'b11
  } qmode_e;
endpackage

// File: rtl/rmq_store.sv
module rmq_store #(
  parameter int NQ    = 4,
  parameter int DEPTH = 16,
  parameter int MSG_W = 32,
  localparam int IW   = $clog2(NQ * DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_a_i,
  input  logic [IW-1:0]    wa_a_i,
  input  logic [MSG_W-1:0] wd_a_i,
  input  logic             we_b_i,
  input  logic [IW-1:0]    wa_b_i,
  input  logic [MSG_W-1:0] wd_b_i,
  input  logic [IW-1:0]    ra_i,
  output logic [MSG_W-1:0] rd_o
);
  logic [MSG_W-1:0] mem_q [NQ*DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_a_i) mem_q[wa_a_i] <= wd_a_i;
    if (we_b_i) mem_q[wa_b_i] <= wd_b_i;
  end

  assign rd_o = mem_q[ra_i];
endmodule

// File: rtl/rmq_qctrl.sv
module rmq_qctrl
  import rmq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int SW   = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  qmode_e           mode_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             ext_req_i,
  input  logic             ntf_req_i,
  input  logic             deq_req_i,
  output logic             ext_ok_o,
  output logic             ntf_ok_o,
  output logic             deq_ok_o,
  output logic [AW-1:0]    ext_slot_o,
  output logic [AW-1:0]    ntf_slot_o,
  output logic [AW-1:0]    head_slot_o,
  output logic             byp_ext_o,
  output logic             byp_ntf_o,
  output logic             wake_ev_o,
  output logic             note_ev_o,
  output logic [PW-1:0]    occ_o,
  output logic [PW-1:0]    head_o
);
  logic [PW-1:0]    head_q, tail_q, head_n, tail_n;
  logic [PW-1:0]    occ, occ1, occ2;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SW-1:0]    sum;
  logic             rise, fire, first_rd;

  always_comb begin
    occ       = tail_q - head_q;
    ext_ok_o  = ext_req_i && (occ < PW'(DEPTH));
    occ1      = occ + PW'(ext_ok_o);
    ntf_ok_o  = ntf_req_i && (occ1 < PW'(DEPTH));
    occ2      = occ1 + PW'(ntf_ok_o);
    deq_ok_o  = deq_req_i && (occ2 != '0);
    tail_n    = tail_q + PW'(ext_ok_o) + PW'(ntf_ok_o);
    head_n    = head_q + PW'(deq_ok_o);
    rise      = (occ == '0) && (tail_n != head_n);
    // empty queue read in the same cycle: data comes from the first write
    first_rd  = deq_ok_o && (occ == '0);
    byp_ext_o = first_rd && ext_ok_o;
    byp_ntf_o = first_rd && !ext_ok_o;
    ext_slot_o  = tail_q[AW-1:0];
    ntf_slot_o  = tail_q[AW-1:0] + AW'(ext_ok_o);
    head_slot_o = head_q[AW-1:0];
    sum  = {1'b0, cnt_q} + SW'(ext_ok_o) + SW'(ntf_ok_o);
    fire = (mode_i == MODE_COUNT) && (thr_i != '0) && (sum >= {1'b0, thr_i});
    if (mode_i != MODE_COUNT) cnt_n = '0;
    else if (fire)            cnt_n = CNT_W'(sum - {1'b0, thr_i});
    else                      cnt_n = CNT_W'(sum);
    wake_ev_o = (mode_i == MODE_WAKE) && rise;
    note_ev_o = ((mode_i == MODE_NOTE) && rise) || fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  assign occ_o  = occ;
  assign head_o = head_q;
endmodule

// File: rtl/rmq_pick.sv
module rmq_pick #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  set_i,
  input  logic          ack_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] pend_q, pend_n, clr;

  always_comb begin
    valid_o = |pend_q;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) idx_o = IW'(i);
    end
    clr    = (ack_i && valid_o) ? (N'(1) << idx_o) : '0;
    pend_n = (pend_q & ~clr) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_n;
  end
endmodule

// File: rtl/rmq_engine.sv
module rmq_engine
  import rmq_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int DEPTH = 16,
  parameter int MSG_W = 32,
  parameter int TID_W = 6,
  parameter int SRC_W = 8,
  parameter int DST_W = 16,
  parameter int CNT_W = 8,
  localparam int QW   = $clog2(NQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*NQ-1:0]     cfg_mode_i,
  input  logic [TID_W*NQ-1:0] cfg_tid_i,
  input  logic [QW*NQ-1:0]    cfg_ntq_i,
  input  logic [CNT_W*NQ-1:0] cfg_thr_i,
  input  logic                enq_valid_i,
  input  logic [QW-1:0]       enq_qid_i,
  input  logic [SRC_W-1:0]    enq_src_i,
  input  logic [MSG_W-1:0]    enq_data_i,
  input  logic                deq_valid_i,
  input  logic [QW-1:0]       deq_qid_i,
  input  logic [DST_W-1:0]    deq_dst_i,
  output logic                enq_rsp_valid_o,
  output logic                enq_rsp_ok_o,
  output logic [SRC_W-1:0]    enq_rsp_src_o,
  output logic                deq_rsp_valid_o,
  output logic                deq_rsp_ok_o,
  output logic [MSG_W-1:0]    deq_rsp_data_o,
  output logic [DST_W-1:0]    deq_rsp_dst_o,
  output logic                wake_valid_o,
  output logic [QW-1:0]       wake_qid_o,
  output logic [TID_W-1:0]    wake_tid_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int IW = QW + AW;

  logic [NQ-1:0] ext_req_v, ntf_req_v, deq_req_v;
  logic [NQ-1:0] ext_ok_v, ntf_ok_v, deq_ok_v;
  logic [NQ-1:0] byp_ext_v, byp_ntf_v, wake_ev_v, note_ev_v;
  logic [AW-1:0] ext_slot_v [NQ];
  logic [AW-1:0] ntf_slot_v [NQ];
  logic [AW-1:0] head_slot_v [NQ];
  logic [NQ*PW-1:0] occ_flat, head_flat;

  logic             ntf_valid;
  logic [QW-1:0]    ntf_idx, ntf_tgt;
  logic [MSG_W-1:0] ntf_msg, rd_data, deq_data;

  logic          we_a, we_b;
  logic [IW-1:0] wa_a, wa_b, ra;

  assign ntf_tgt = cfg_ntq_i[ntf_idx*QW +: QW];
  assign ntf_msg = {1'b1, {(MSG_W-1-QW){1'b0}}, ntf_idx};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign ext_req_v[q] = enq_valid_i && (enq_qid_i == QW'(q));
    assign ntf_req_v[q] = ntf_valid && (ntf_tgt == QW'(q));
    assign deq_req_v[q] = deq_valid_i && (deq_qid_i == QW'(q));

    rmq_qctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (qmode_e'(cfg_mode_i[2*q +: 2])),
      .thr_i      (cfg_thr_i[CNT_W*q +: CNT_W]),
      .ext_req_i  (ext_req_v[q]),
      .ntf_req_i  (ntf_req_v[q]),
      .deq_req_i  (deq_req_v[q]),
      .ext_ok_o   (ext_ok_v[q]),
      .ntf_ok_o   (ntf_ok_v[q]),
      .deq_ok_o   (deq_ok_v[q]),
      .ext_slot_o (ext_slot_v[q]),
      .ntf_slot_o (ntf_slot_v[q]),
      .head_slot_o(head_slot_v[q]),
      .byp_ext_o  (byp_ext_v[q]),
      .byp_ntf_o  (byp_ntf_v[q]),
      .wake_ev_o  (wake_ev_v[q]),
      .note_ev_o  (note_ev_v[q]),
      .occ_o      (occ_flat[PW*q +: PW]),
      .head_o     (head_flat[PW*q +: PW])
    );
  end

  rmq_pick #(.N(NQ)) u_note_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (note_ev_v),
    .ack_i  (|ntf_ok_v),
    .valid_o(ntf_valid),
    .idx_o  (ntf_idx)
  );

  rmq_pick #(.N(NQ)) u_wake_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wake_ev_v),
    .ack_i  (1'b1),
    .valid_o(wake_valid_o),
    .idx_o  (wake_qid_o)
  );

  assign wake_tid_o = cfg_tid_i[wake_qid_o*TID_W +: TID_W];

  assign we_a = |ext_ok_v;
  assign wa_a = {enq_qid_i, ext_slot_v[enq_qid_i]};
  assign we_b = |ntf_ok_v;
  assign wa_b = {ntf_tgt, ntf_slot_v[ntf_tgt]};
  assign ra   = {deq_qid_i, head_slot_v[deq_qid_i]};

  rmq_store #(.NQ(NQ), .DEPTH(DEPTH), .MSG_W(MSG_W)) u_store (
    .clk_i (clk_i),
    .we_a_i(we_a),
    .wa_a_i(wa_a),
    .wd_a_i(enq_data_i),
    .we_b_i(we_b),
    .wa_b_i(wa_b),
    .wd_b_i(ntf_msg),
    .ra_i  (ra),
    .rd_o  (rd_data)
  );

  always_comb begin
    if (byp_ext_v[deq_qid_i])      deq_data = enq_data_i;
    else if (byp_ntf_v[deq_qid_i]) deq_data = ntf_msg;
    else                           deq_data = rd_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enq_rsp_valid_o <= 1'b0;
      enq_rsp_ok_o    <= 1'b0;
      enq_rsp_src_o   <= '0;
      deq_rsp_valid_o <= 1'b0;
      deq_rsp_ok_o    <= 1'b0;
      deq_rsp_data_o  <= '0;
      deq_rsp_dst_o   <= '0;
    end else begin
      enq_rsp_valid_o <= enq_valid_i;
      enq_rsp_ok_o    <= we_a;
      enq_rsp_src_o   <= enq_src_i;
      deq_rsp_valid_o <= deq_valid_i;
      deq_rsp_ok_o    <= |deq_ok_v;
      deq_rsp_data_o  <= (|deq_ok_v) ? deq_data : '0;
      deq_rsp_dst_o   <= deq_dst_i;
    end
  end
endmodule

// File: rtl/rmq_engine_chk.sv
module rmq_engine_chk #(
  parameter int NQ    = 4,
  parameter int DEPTH = 16,
  parameter int MSG_W = 32,
  parameter int PW    = 5,
  parameter int IW    = 6,
  parameter int QW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enq_valid_i,
  input logic             deq_valid_i,
  input logic             enq_rsp_valid_o,
  input logic             deq_rsp_valid_o,
  input logic             deq_rsp_ok_o,
  input logic [MSG_W-1:0] deq_rsp_data_o,
  input logic [NQ*PW-1:0] occ_flat,
  input logic [NQ*PW-1:0] head_flat,
  input logic             we_a,
  input logic             we_b,
  input logic [IW-1:0]    wa_a,
  input logic [IW-1:0]    wa_b,
  input logic             wake_valid_o,
  input logic [QW-1:0]    wake_qid_o,
  input logic [2*NQ-1:0]  cfg_mode_i
);
  assert_enq_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_valid_i |=> enq_rsp_valid_o);

  assert_enq_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enq_valid_i |=> !enq_rsp_valid_o);

  assert_deq_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_i |=> deq_rsp_valid_o);

  assert_head_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deq_valid_i |=> $stable(head_flat));

  assert_distinct_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a && we_b) |-> (wa_a != wa_b));

  for (genvar q = 0; q < NQ; q++) begin : g_occ
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_flat[PW*q +: PW] <= PW'(DEPTH));
  end

  assert_empty_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_rsp_valid_o && !deq_rsp_ok_o) |-> (deq_rsp_data_o == '0));

  assert_wake_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_valid_o |-> (cfg_mode_i[2*wake_qid_o +: 2] == 2'b01));
endmodule

bind rmq_engine rmq_engine_chk #(
  .NQ(NQ), .DEPTH(DEPTH), .MSG_W(MSG_W), .PW(PW), .IW(IW), .QW(QW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enq_valid_i    (enq_valid_i),
  .deq_valid_i    (deq_valid_i),
  .enq_rsp_valid_o(enq_rsp_valid_o),
  .deq_rsp_valid_o(deq_rsp_valid_o),
  .deq_rsp_ok_o   (deq_rsp_ok_o),
  .deq_rsp_data_o (deq_rsp_data_o),
  .occ_flat       (occ_flat),
  .head_flat      (head_flat),
  .we_a           (we_a),
  .we_b           (we_b),
  .wa_a           (wa_a),
  .wa_b           (wa_b),
  .wake_valid_o   (wake_valid_o),
  .wake_qid_o     (wake_qid_o),
  .cfg_mode_i     (cfg_mode_i)
);

// File: tb/rmq_engine_test.sv
module rmq_engine_test;
  localparam int NQ = 4, DEPTH = 16, MSG_W = 32, TID_W = 6;
  localparam int SRC_W = 8, DST_W = 16, CNT_W = 8, QW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [2*NQ-1:0]     cfg_mode = '0;
  logic [TID_W*NQ-1:0] cfg_tid = '0;
  logic [QW*NQ-1:0]    cfg_ntq = '0;
  logic [CNT_W*NQ-1:0] cfg_thr = '0;
  logic             enq_valid = 1'b0, deq_valid = 1'b0;
  logic [QW-1:0]    enq_qid = '0, deq_qid = '0;
  logic [SRC_W-1:0] enq_src = '0;
  logic [MSG_W-1:0] enq_data = '0;
  logic [DST_W-1:0] deq_dst = '0;
  logic             enq_rsp_valid, enq_rsp_ok, deq_rsp_valid, deq_rsp_ok, wake_valid;
  logic [SRC_W-1:0] enq_rsp_src;
  logic [MSG_W-1:0] deq_rsp_data;
  logic [DST_W-1:0] deq_rsp_dst;
  logic [QW-1:0]    wake_qid;
  logic [TID_W-1:0] wake_tid;

  rmq_engine uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_mode_i(cfg_mode), .cfg_tid_i(cfg_tid), .cfg_ntq_i(cfg_ntq), .cfg_thr_i(cfg_thr),
    .enq_valid_i(enq_valid), .enq_qid_i(enq_qid), .enq_src_i(enq_src), .enq_data_i(enq_data),
    .deq_valid_i(deq_valid), .deq_qid_i(deq_qid), .deq_dst_i(deq_dst),
    .enq_rsp_valid_o(enq_rsp_valid), .enq_rsp_ok_o(enq_rsp_ok), .enq_rsp_src_o(enq_rsp_src),
    .deq_rsp_valid_o(deq_rsp_valid), .deq_rsp_ok_o(deq_rsp_ok),
    .deq_rsp_data_o(deq_rsp_data), .deq_rsp_dst_o(deq_rsp_dst),
    .wake_valid_o(wake_valid), .wake_qid_o(wake_qid), .wake_tid_o(wake_tid)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [MSG_W-1:0] dat(input int q, input int i);
    return 32'h1000_0000 | MSG_W'(q << 8) | MSG_W'(i);
  endfunction

  function automatic logic [MSG_W-1:0] note(input int q);
    return 32'h8000_0000 | MSG_W'(q);
  endfunction

  // one cycle: inputs set at a falling edge, outputs read at the next one
  task automatic step(input bit ev, input int eq, input logic [MSG_W-1:0] ed,
                      input bit dv, input int dq, input int tag);
    enq_valid = ev; enq_qid = QW'(eq); enq_data = ed; enq_src = SRC_W'(tag);
    deq_valid = dv; deq_qid = QW'(dq); deq_dst = DST_W'(tag + 1000);
    @(posedge clk);
    @(negedge clk);
    enq_valid = 1'b0; deq_valid = 1'b0;
  endtask

  task automatic set_mode(input int q, input logic [1:0] m);
    cfg_mode[2*q +: 2] = m;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 enq_rsp_valid", 64'(enq_rsp_valid), 0);
    chk("R11 deq_rsp_valid", 64'(deq_rsp_valid), 0);
    chk("R11 wake_valid", 64'(wake_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 outputs idle after release", 64'({enq_rsp_valid, deq_rsp_valid, wake_valid}), 0);
    for (int q = 0; q < NQ; q++) begin
      step(0, 0, '0, 1, q, 7);
      chk("R11 empty after reset", 64'({deq_rsp_valid, deq_rsp_ok}), 64'b10);
    end

    // fill every queue past capacity with modes off
    for (int q = 0; q < NQ; q++) begin
      for (int i = 0; i <= DEPTH; i++) begin
        step(1, q, dat(q, i), 0, 0, q * 17 + i);
        chk("R1 enq_rsp_valid", 64'(enq_rsp_valid), 1);
        chk(i < DEPTH ? "R1 accept" : "R3 NACK when full", 64'(enq_rsp_ok), 64'(i < DEPTH));
        chk("R1 src echo", 64'(enq_rsp_src), 64'(q * 17 + i));
        chk("R10 no wake when off", 64'(wake_valid), 0);
      end
    end
    // drain: order, contents and isolation
    for (int q = 0; q < NQ; q++) begin
      for (int i = 0; i <= DEPTH; i++) begin
        step(0, 0, '0, 1, q, q * 40 + i);
        chk("R4 deq_rsp_valid", 64'(deq_rsp_valid), 1);
        chk(i < DEPTH ? "R4 ok" : "R5 empty flag", 64'(deq_rsp_ok), 64'(i < DEPTH));
        chk(i < DEPTH ? "R4 R12 R3 FIFO data" : "R5 zero data", 64'(deq_rsp_data),
            i < DEPTH ? 64'(dat(q, i)) : 64'd0);
        chk("R4 dst echo", 64'(deq_rsp_dst), 64'(q * 40 + i + 1000));
      end
    end

    // same-cycle enqueue and dequeue on an empty queue
    step(1, 2, 32'hCAFE_0002, 1, 2, 3);
    chk("R6 enq ok", 64'(enq_rsp_ok), 1);
    chk("R6 deq ok", 64'(deq_rsp_ok), 1);
    chk("R6 data bypass", 64'(deq_rsp_data), 64'h0000_0000_CAFE_0002);
    step(0, 0, '0, 1, 2, 4);
    chk("R6 queue left empty", 64'(deq_rsp_ok), 0);

    // wake mode
    set_mode(1, 2'b01);
    cfg_tid[TID_W*1 +: TID_W] = 6'h2A;
    step(1, 1, 32'h11, 0, 0, 5);
    chk("R7 wake_valid", 64'(wake_valid), 1);
    chk("R7 wake_qid", 64'(wake_qid), 1);
    chk("R7 wake_tid", 64'(wake_tid), 64'h2A);
    step(0, 0, '0, 0, 0, 6);
    chk("R7 one-cycle wake", 64'(wake_valid), 0);
    step(1, 1, 32'h12, 0, 0, 7);
    chk("R7 no wake when non-empty", 64'(wake_valid), 0);
    step(0, 0, '0, 1, 1, 8);
    step(0, 0, '0, 1, 1, 9);
    chk("R7 drain data", 64'(deq_rsp_data), 64'h12);
    set_mode(1, 2'b00);
    step(0, 0, '0, 0, 0, 10);

    // notify mode: queue 0 reports into queue 3
    set_mode(0, 2'b10);
    cfg_ntq[QW*0 +: QW] = 2'd3;
    step(1, 0, 32'h21, 0, 0, 11);
    step(0, 0, '0, 0, 0, 12);
    step(0, 0, '0, 1, 3, 13);
    chk("R8 notify present", 64'(deq_rsp_ok), 1);
    chk("R8 notify message", 64'(deq_rsp_data), 64'(note(0)));
    step(0, 0, '0, 1, 3, 14);
    chk("R8 single notify", 64'(deq_rsp_ok), 0);
    step(0, 0, '0, 1, 0, 15);
    chk("R8 source data kept", 64'(deq_rsp_data), 64'h21);

    // notification and external enqueue into queue 3 in one cycle
    step(1, 0, 32'h22, 0, 0, 16);
    step(1, 3, 32'h33, 0, 0, 17);
    chk("R2 external accepted", 64'(enq_rsp_ok), 1);
    step(0, 0, '0, 1, 3, 18);
    chk("R2 external first", 64'(deq_rsp_data), 64'h33);
    step(0, 0, '0, 1, 3, 19);
    chk("R2 notify second", 64'(deq_rsp_data), 64'(note(0)));
    step(0, 0, '0, 1, 3, 20);
    chk("R2 exactly two", 64'(deq_rsp_ok), 0);
    step(0, 0, '0, 1, 0, 21);
    set_mode(0, 2'b00);

    // count mode: queue 1, threshold 3, reports into queue 2
    set_mode(1, 2'b11);
    cfg_thr[CNT_W*1 +: CNT_W] = 8'd3;
    cfg_ntq[QW*1 +: QW] = 2'd2;
    for (int i = 0; i < 7; i++) begin
      step(1, 1, dat(1, i), 0, 0, 30 + i);
      chk("R9 no wake in count mode", 64'(wake_valid), 0);
    end
    step(0, 0, '0, 0, 0, 40);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, '0, 1, 2, 41 + i);
      chk("R9 notify count", 64'(deq_rsp_ok), 64'(i < 2));
      chk("R9 notify message", 64'(deq_rsp_data), i < 2 ? 64'(note(1)) : 64'd0);
    end
    for (int i = 0; i < 7; i++) begin
      step(0, 0, '0, 1, 1, 50 + i);
      chk("R9 R12 source order", 64'(deq_rsp_data), 64'(dat(1, i)));
    end
    cfg_thr[CNT_W*1 +: CNT_W] = 8'd0;
    for (int i = 0; i < 4; i++) step(1, 1, dat(1, i), 0, 0, 60 + i);
    step(0, 0, '0, 0, 0, 64);
    step(0, 0, '0, 1, 2, 65);
    chk("R9 zero threshold silent", 64'(deq_rsp_ok), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule